// File: doc/BRIEF.md
# Line-Locked Serial Status Transmitter

This block sends a short status frame on one output wire once per video line. A falling transition on the line reference input starts an internal cycle count. The frame is timed from that point. After a fixed lead-in of 128 clocks, the block sends the following bits in order:

- a marker bit,
- a system-clock frequency word,
- a colour-subcarrier frequency word,
- one colour-sequence bit.

A silent reserve interval follows. Its length depends on the line standard. When it ends, the block accepts the next line edge.

The frequency words, the colour standard, the sequence phase, the line standard and the per-bit hold length come from parallel inputs. All of them are captured when a frame starts. Anything that changes on those inputs afterwards cannot disturb a frame that is already being sent. The receiving side only needs to count clocks from the same line edge to know which bit is on the wire.

Top module: `line_status_tx`

## Requirements
- R1: While `rstN` is low, and right after reset is released, `serOut` is 0 and no frame is active.
- R2: A frame starts only on a clock edge where `lineRef` is sampled low while the previous sample was high and no frame is active. Holding `lineRef` low, or taking it from low to high, starts nothing.
- R3: `serOut` stays 0 for the first 127 cycles after the start edge. The first frame bit appears on the output 128 cycles after the start edge.
- R4: The frame is sent in this order: a marker bit of 1, then `clkWord` MSB first, then `subWord` MSB first, then the sequence bit.
- R5: Each frame bit is held for `holdLen` clock cycles. A `holdLen` of 0 is treated as 1.
- R6: The sequence bit is `seqLine` when `colorStd` is 1 (PAL: 1 means inverted line) or 2 (SECAM: 1 means DR line). It is 0 when `colorStd` is 0 (NTSC) or 3.
- R7: After the last frame bit, `serOut` is 0 for a reserve interval of 276 cycles when `mode60` is 0, or 188 cycles when `mode60` is 1. A start edge is accepted on the first clock edge after that interval.
- R8: `clkWord`, `subWord`, `colorStd`, `seqLine`, `holdLen` and `mode60` are captured at the start edge. Changing them during a frame has no effect on that frame.
- R9: A falling edge on `lineRef` that arrives while a frame is active is ignored. It neither restarts nor shifts the frame.
- R10: Outside a frame (idle), `serOut` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-locked clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineRef | input | 1 | Line reference; its high-to-low transition starts a frame |
| mode60 | input | 1 | Line standard: 0 = 50 Hz, 1 = 60 Hz |
| colorStd | input | 2 | Colour standard: 0 NTSC, 1 PAL, 2 SECAM, 3 none |
| seqLine | input | 1 | Line sequence phase for PAL or SECAM |
| holdLen | input | HOLD_W | Clocks per frame bit (0 means 1) |
| clkWord | input | CLK_WORD_W | System-clock frequency word |
| subWord | input | SUB_WORD_W | Subcarrier frequency word |
| serOut | output | 1 | Serial status output |

## Verification
The bench builds the block with a 6-bit clock word, a 5-bit subcarrier word and a 3-bit hold field. These short words keep each frame near 450 cycles, so many complete frames fit in one run. They also make every hold value from 0 to 7 reachable, including the 0-means-1 case and the maximum. Frames are run with both line standards and all four colour-standard codes. Line edges and input changes are placed in the lead-in, data and reserve regions of a frame. A back-to-back start is placed on the very first cycle after a reserve interval ends.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_DATA,
    ST_RESV
  } lssState_e;

  typedef struct packed {
    logic load;   // capture inputs into the frame register
    logic emit;   // present next frame bit on the output
    logic quiet;  // force the output low (end of data)
  } lssStrobe_t;

  localparam logic [1:0] STD_NTSC  = 2'd0;
  localparam logic [1:0] STD_PAL   = 2'd1;
  localparam logic [1:0] STD_SECAM = 2'd2;
endpackage

// File: rtl/lss_ctrl.sv
module lss_ctrl
  import lss_pkg::*;
#(
  parameter int LEAD_CLKS  = 128,
  parameter int RESV_50    = 276,
  parameter int RESV_60    = 188,
  parameter int FRAME_BITS = 34,
  parameter int HOLD_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineRef,
  input  logic              mode60,
  input  logic [HOLD_W-1:0] holdLen,
  output lssStrobe_t        strobe,
  output logic              busy
);
  localparam int CNT_MAX = (LEAD_CLKS > RESV_50) ?
                           ((LEAD_CLKS > RESV_60) ? LEAD_CLKS : RESV_60) :
                           ((RESV_50 > RESV_60) ? RESV_50 : RESV_60);
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_CLKS - 1);
  localparam logic [CNT_W-1:0] R50_LAST  = CNT_W'(RESV_50 - 1);
  localparam logic [CNT_W-1:0] R60_LAST  = CNT_W'(RESV_60 - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BITS - 1);

  lssState_e         state;
  logic              prevRef;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  resvLast;
  logic [HOLD_W-1:0] holdCnt;
  logic [HOLD_W-1:0] holdLast;
  logic [IDX_W-1:0]  bitIdx;
  logic              startEdge;
  logic              bitDone;
  logic              lastBit;

  assign startEdge = prevRef & ~lineRef;
  assign bitDone   = (holdCnt == holdLast);
  assign lastBit   = (bitIdx == IDX_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      prevRef  <= 1'b0;
      cnt      <= '0;
      resvLast <= '0;
      holdCnt  <= '0;
      holdLast <= '0;
      bitIdx   <= '0;
    end else begin
      prevRef <= lineRef;
      case (state)
        ST_IDLE: begin
          if (startEdge) begin
            state    <= ST_LEAD;
            cnt      <= '0;
            holdLast <= (holdLen == '0) ? '0 : holdLen - 1'b1;
            resvLast <= mode60 ? R60_LAST : R50_LAST;
          end
        end
        ST_LEAD: begin
          if (cnt == LEAD_LAST) begin
            state   <= ST_DATA;
            holdCnt <= '0;
            bitIdx  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bitDone) begin
            holdCnt <= '0;
            if (lastBit) begin
              state <= ST_RESV;
              cnt   <= '0;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
        ST_RESV: begin
          if (cnt == resvLast) state <= ST_IDLE;
          else                 cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.load  = (state == ST_IDLE) && startEdge;
    strobe.emit  = ((state == ST_LEAD) && (cnt == LEAD_LAST)) ||
                   ((state == ST_DATA) && bitDone && !lastBit);
    strobe.quiet = (state == ST_DATA) && bitDone && lastBit;
  end

  assign busy = (state != ST_IDLE);

  AST_LEAD_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LEAD && cnt != LEAD_LAST) |=>
      (state == ST_LEAD && cnt == $past(cnt) + 1'b1)); // R9

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && !bitDone) |=> $stable(bitIdx)); // R5

  AST_RESV_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESV) |-> (cnt <= resvLast)); // R7
endmodule

// File: rtl/lss_data.sv
module lss_data
  import lss_pkg::*;
#(
  parameter int CLK_WORD_W = 16,
  parameter int SUB_WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lssStrobe_t            strobe,
  input  logic [CLK_WORD_W-1:0] clkWord,
  input  logic [SUB_WORD_W-1:0] subWord,
  input  logic [1:0]            colorStd,
  input  logic                  seqLine,
  output logic                  serOut
);
  localparam int FRAME_BITS = CLK_WORD_W + SUB_WORD_W + 2;

  logic [FRAME_BITS-1:0] frameReg;
  logic                  seqBit;
  logic                  outBit;

  always_comb begin
    case (colorStd)
      STD_PAL, STD_SECAM: seqBit = seqLine;
      default:            seqBit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '0;
      outBit   <= 1'b0;
    end else if (strobe.load) begin
      frameReg <= {1'b1, clkWord, subWord, seqBit};
    end else if (strobe.emit) begin
      outBit   <= frameReg[FRAME_BITS-1];
      frameReg <= {frameReg[FRAME_BITS-2:0], 1'b0};
    end else if (strobe.quiet) begin
      outBit <= 1'b0;
    end
  end

  assign serOut = outBit;

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.emit, strobe.quiet})); // R4

  AST_LEAD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !serOut); // R3
endmodule

// File: rtl/line_status_tx.sv
module line_status_tx
  import lss_pkg::*;
#(
  parameter int CLK_WORD_W = 16,
  parameter int SUB_WORD_W = 16,
  parameter int HOLD_W     = 4,
  parameter int LEAD_CLKS  = 128,
  parameter int RESV_50    = 276,
  parameter int RESV_60    = 188
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lineRef,
  input  logic                  mode60,
  input  logic [1:0]            colorStd,
  input  logic                  seqLine,
  input  logic [HOLD_W-1:0]     holdLen,
  input  logic [CLK_WORD_W-1:0] clkWord,
  input  logic [SUB_WORD_W-1:0] subWord,
  output logic                  serOut
);
  localparam int FRAME_BITS = CLK_WORD_W + SUB_WORD_W + 2;

  lssStrobe_t strobe;
  logic       busy;

  lss_ctrl #(
    .LEAD_CLKS (LEAD_CLKS),
    .RESV_50   (RESV_50),
    .RESV_60   (RESV_60),
    .FRAME_BITS(FRAME_BITS),
    .HOLD_W    (HOLD_W)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .lineRef(lineRef),
    .mode60 (mode60),
    .holdLen(holdLen),
    .strobe (strobe),
    .busy   (busy)
  );

  lss_data #(
    .CLK_WORD_W(CLK_WORD_W),
    .SUB_WORD_W(SUB_WORD_W)
  ) i_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .clkWord (clkWord),
    .subWord (subWord),
    .colorStd(colorStd),
    .seqLine (seqLine),
    .serOut  (serOut)
  );

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !serOut); // R10
endmodule

// File: tb/test_line_status_tx.sv
module test_line_status_tx;
  localparam int CW = 6;
  localparam int SW = 5;
  localparam int HW = 3;
  localparam int NB = CW + SW + 2;
  localparam int LEAD = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lineRef = 1'b0;
  logic          mode60 = 1'b0;
  logic [1:0]    colorStd = 2'd0;
  logic          seqLine = 1'b0;
  logic [HW-1:0] holdLen = '0;
  logic [CW-1:0] clkWord = '0;
  logic [SW-1:0] subWord = '0;
  logic          serOut;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  string scen = "R1";

  // reference model state
  bit    mPrev = 1'b0;
  bit    mActive = 1'b0;
  int    mN = 0;
  int    mH = 1;
  int    mR = 276;
  bit    mBits[$];
  bit    expOut = 1'b0;
  string region = "R1";

  always #5 clk = ~clk;

  line_status_tx #(
    .CLK_WORD_W(CW),
    .SUB_WORD_W(SW),
    .HOLD_W    (HW)
  ) i_line_status_tx (
    .clk     (clk),
    .rstN    (rstN),
    .lineRef (lineRef),
    .mode60  (mode60),
    .colorStd(colorStd),
    .seqLine (seqLine),
    .holdLen (holdLen),
    .clkWord (clkWord),
    .subWord (subWord),
    .serOut  (serOut)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mPrev = 1'b0; mActive = 1'b0; expOut = 1'b0; region = "R1";
    end else begin
      if (!mActive) begin
        if (mPrev && !lineRef) begin
          mActive = 1'b1;
          mN = 0;
          mH = (holdLen == 0) ? 1 : int'(holdLen);
          mR = mode60 ? 188 : 276;
          mBits.delete();
          mBits.push_back(1'b1);
          for (int i = CW - 1; i >= 0; i--) mBits.push_back(clkWord[i]);
          for (int i = SW - 1; i >= 0; i--) mBits.push_back(subWord[i]);
          mBits.push_back((colorStd == 2'd1 || colorStd == 2'd2) ? seqLine : 1'b0);
          expOut = 1'b0; region = "R3";
        end else begin
          expOut = 1'b0; region = "R10";
        end
      end else begin
        mN++;
        if (mN < LEAD) begin
          expOut = 1'b0; region = "R3";
        end else if (mN < LEAD + NB * mH) begin
          expOut = mBits[(mN - LEAD) / mH]; region = "R4";
        end else begin
          expOut = 1'b0; region = "R7";
        end
        if (mN == LEAD + NB * mH + mR) mActive = 1'b0;
      end
      mPrev = lineRef;
    end
  end

  always @(negedge clk) begin
    compared++;
    if (serOut !== expOut) begin
      mismatched++;
      $display("FAIL %s/%s cycle %0d: serOut=%0b expected %0b",
               scen, region, cyc, serOut, expOut);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      mismatched++;
      $display("FAIL watchdog %s: cycles=%0d expected completion", scen, cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fallEdge();
    @(negedge clk) lineRef = 1'b1;
    @(negedge clk) lineRef = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (mActive) @(negedge clk);
    cycles(3);
  endtask

  task automatic setUp(input bit m60, input logic [1:0] std, input bit sq,
                       input int hl, input int cw, input int sw);
    mode60 = m60; colorStd = std; seqLine = sq;
    holdLen = HW'(hl); clkWord = CW'(cw); subWord = SW'(sw);
  endtask

  initial begin
    cycles(3);
    // R1: output low during reset
    compared++;
    if (serOut !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: serOut=%0b expected 0 in reset", serOut);
    end
    rstN = 1'b1;
    cycles(5);

    scen = "R2";   // basic PAL frame, 50 Hz, hold 2
    setUp(1'b0, 2'd1, 1'b1, 2, 'h2D, 'h13);
    fallEdge(); waitIdle();

    scen = "R5";   // hold 0 treated as 1, SECAM DR, 60 Hz
    setUp(1'b1, 2'd2, 1'b1, 0, 'h3F, 'h00);
    fallEdge(); waitIdle();

    scen = "R6";   // NTSC forces sequence bit to 0
    setUp(1'b0, 2'd0, 1'b1, 1, 'h00, 'h1F);
    fallEdge(); waitIdle();

    scen = "R6";   // code 3 forces 0, maximum hold
    setUp(1'b1, 2'd3, 1'b1, 7, 'h15, 'h0A);
    fallEdge(); waitIdle();

    scen = "R8";   // inputs change mid-frame; R9 edges mid-frame
    setUp(1'b0, 2'd2, 1'b0, 3, 'h31, 'h05);
    fallEdge();
    cycles(60);
    setUp(1'b1, 2'd1, 1'b1, 1, 'h0E, 'h1B);
    scen = "R9";
    fallEdge();     // during lead-in
    cycles(90);
    fallEdge();     // during data bits
    cycles(80);
    fallEdge();     // during reserve
    waitIdle();

    scen = "R2";   // held low then rising: no start
    lineRef = 1'b0;
    cycles(300);
    lineRef = 1'b1;
    cycles(300);
    lineRef = 1'b0; // this fall does start a frame (hold 1, PAL)
    waitIdle();

    scen = "R7";   // back-to-back start right after the reserve ends
    setUp(1'b1, 2'd1, 1'b0, 2, 'h2A, 'h15);
    fallEdge();
    @(negedge clk);
    while (mActive && mN < LEAD + NB * mH + 10) @(negedge clk);
    lineRef = 1'b1;
    while (mActive) @(negedge clk);
    setUp(1'b0, 2'd2, 1'b1, 4, 'h01, 'h10);
    lineRef = 1'b0;
    waitIdle();

    cycles(5);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule